// File: doc/BRIEF.md
# Bus-Snooping Control-Flow Integrity Monitor

This block sits beside a processor's memory bus and watches each valid bus cycle: address, the opcode field of the data word, and the read/write line. It holds no program state of its own beyond a small automaton. The automaton follows the running program at function granularity. It uses a call-return graph model supplied on static configuration inputs. These inputs give the address span of each function, the call targets each function may reach indirectly, the sites each function may return to, and the landing sites allowed for a non-local jump.

When the automaton fetches a call, return, indirect jump or memory instruction, it enters a task mode for exactly one further valid cycle. In that cycle the bus address is the destination, and it is checked against the model in parallel. Direct and conditional branches are not followed, because their targets live in code that the block already guards against writes. A per-function counter bank records calls made from each function and returns made into it. Any violation raises a sticky code or control attack flag. It also freezes the whole monitor and records where the offending instruction was fetched and where it tried to go. Only a reset clears this state.

Top module: `cfm_monitor`

## Requirements
- R1: After reset the mode output reads 0 (dispatcher), the active function is 0, both attack flags are low, every call counter is zero and both diagnosis addresses are zero.
- R2: A cycle with `bus_vld` low changes nothing, whatever the address, opcode or write line carry.
- R3: In dispatcher mode an address outside [`code_lo`, `code_hi`] causes no action. A write to an address inside that range, in dispatcher mode or in the access cycle of a load/store, moves the mode to 6 and raises `code_atk`.
- R4: On a code read in dispatcher mode the opcode field (data bits 31:26) picks the next mode. 0x01 gives mode 1 (direct call), 0x02 gives 2 (indirect call), 0x03 gives 3 (return), 0x04 gives 4 (indirect jump), and 0x05 or 0x06 give 5 (load/store). Every other value, branches included, stays in mode 0. A task mode lasts one valid cycle and then returns to 0 unless a violation occurs.
- R5: In the cycle after a direct call the address must equal the first address of some function. That function becomes active and the caller's counter rises by one; otherwise the mode moves to 7 and `ctrl_atk` rises.
- R6: An indirect call target must match a valid entry in the active function's call table and also be the first address of a function. If it does, the update is the same as for a direct call; otherwise a control attack is raised.
- R7: A return destination must match a valid entry in the active function's return-site table. If it does, the function whose span holds it becomes active and that function's counter drops by one, saturating at zero. Otherwise a control attack is raised.
- R8: An indirect jump must land inside the active function's span. When the active function equals `lj_fn`, it must instead match a valid non-local landing site, and the function holding that site becomes active. Any other landing raises a control attack.
- R9: The access cycle of a load/store is not decoded as a fetch, even when it reads a code address carrying a control opcode.
- R10: Once either attack flag is high, the mode, flags, active function, counters and diagnosis addresses hold until reset.
- R11: At a violation `diag_src` takes the address of the latest code read in dispatcher mode, and `diag_dst` takes the offending bus address.

Table layout: function f's span is `fn_lo_tab`/`fn_hi_tab` bits [16f+15:16f]. Entry e of function f in the call and return tables is at bits [64f+16e+15:64f+16e], with its valid bit at [4f+e].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, the only way out of an attack state |
| bus_vld | input | 1 | Bus cycle qualifier |
| bus_wr | input | 1 | 1 for a write cycle |
| bus_addr | input | 16 | Bus address |
| bus_opc | input | 6 | Opcode field (bits 31:26) of the data word |
| code_lo | input | 16 | Lowest code address |
| code_hi | input | 16 | Highest code address |
| fn_lo_tab | input | 64 | First address of each function |
| fn_hi_tab | input | 64 | Last address of each function |
| call_tab | input | 256 | Permitted indirect-call targets per function |
| call_vld | input | 16 | Valid bits of `call_tab` |
| ret_tab | input | 256 | Permitted return sites per function |
| ret_vld | input | 16 | Valid bits of `ret_tab` |
| sj_tab | input | 64 | Landing sites for non-local jumps |
| sj_vld | input | 4 | Valid bits of `sj_tab` |
| lj_fn | input | 2 | Index of the non-local jump function |
| mode_o | output | 3 | Current monitor mode |
| act_fn | output | 2 | Active function index |
| call_cnt | output | 32 | Call counters, function f in bits [8f+7:8f] |
| code_atk | output | 1 | Sticky code attack flag |
| ctrl_atk | output | 1 | Sticky control attack flag |
| diag_src | output | 16 | Fetch address behind the violation |
| diag_dst | output | 16 | Offending destination or write address |

## Verification
A wrong mode register shows at `mode_o` on the clock edge after the fetch that set it. It shows at `act_fn` or `call_cnt` after the next valid cycle, since a missed or extra task cycle either swallows the destination or treats it as a fresh fetch. A wrong table selection stays hidden until a check is made against the active function's row. At that point a legal transfer raises `ctrl_atk`, or a forged one keeps the flag low, one edge after the destination cycle. Counter drift is visible as soon as the call or return completes. Because the attack state freezes everything, any later wrong update appears as a change in frozen outputs.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

  localparam int OPW = 6;

  typedef enum logic [2:0] {
    MD_DISP     = 3'd0,
    MD_DCALL    = 3'd1,
    MD_ICALL    = 3'd2,
    MD_RET      = 3'd3,
    MD_IJMP     = 3'd4,
    MD_LDST     = 3'd5,
    MD_CODE_ATK = 3'd6,
    MD_CTRL_ATK = 3'd7
  } cfm_mode_e;

  localparam logic [OPW-1:0] OP_DCALL = 6'h01;
  localparam logic [OPW-1:0] OP_ICALL = 6'h02;
  localparam logic [OPW-1:0] OP_RET   = 6'h03;
  localparam logic [OPW-1:0] OP_IJMP  = 6'h04;
  localparam logic [OPW-1:0] OP_LOAD  = 6'h05;
  localparam logic [OPW-1:0] OP_STORE = 6'h06;

  // Opcode class to the mode that inspects the following bus cycle.
  function automatic cfm_mode_e op_to_mode(input logic [OPW-1:0] op);
    case (op)
      OP_DCALL:          return MD_DCALL;
      OP_ICALL:          return MD_ICALL;
      OP_RET:            return MD_RET;
      OP_IJMP:           return MD_IJMP;
      OP_LOAD, OP_STORE: return MD_LDST;
      default:           return MD_DISP;
    endcase
  endfunction

  // Inclusive span test on zero-extended addresses.
  function automatic logic in_span(input logic [31:0] a, input logic [31:0] lo,
                                   input logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic is_task(input cfm_mode_e m);
    return (m == MD_DCALL) || (m == MD_ICALL) || (m == MD_RET) ||
           (m == MD_IJMP) || (m == MD_LDST);
  endfunction

  function automatic logic is_attack(input cfm_mode_e m);
    return (m == MD_CODE_ATK) || (m == MD_CTRL_ATK);
  endfunction

endpackage

// File: rtl/cfm_op_decode.sv
module cfm_op_decode
  import cfm_pkg::*;
(
  input  logic [OPW-1:0] opc,
  output cfm_mode_e      next_mode
);
  always_comb next_mode = op_to_mode(opc);
endmodule

// File: rtl/cfm_edge_match.sv
module cfm_edge_match #(
  parameter int AW = 16,
  parameter int NE = 4
) (
  input  logic [AW-1:0]    addr,
  input  logic [NE*AW-1:0] tab,
  input  logic [NE-1:0]    vld,
  output logic             hit
);
  logic [NE-1:0] slot_hit;

  for (genvar e = 0; e < NE; e++) begin : g_slot
    assign slot_hit[e] = vld[e] && (tab[e*AW +: AW] == addr);
  end

  assign hit = |slot_hit;
endmodule

// File: rtl/cfm_fn_locate.sv
module cfm_fn_locate
  import cfm_pkg::*;
#(
  parameter int AW = 16,
  parameter int NF = 4,
  localparam int FW = $clog2(NF)
) (
  input  logic [AW-1:0]    addr,
  input  logic [NF*AW-1:0] lo_tab,
  input  logic [NF*AW-1:0] hi_tab,
  output logic             entry_hit,
  output logic [FW-1:0]    entry_idx,
  output logic             span_hit,
  output logic [FW-1:0]    span_idx
);
  // Lowest index wins when spans overlap.
  always_comb begin
    entry_hit = 1'b0;
    entry_idx = '0;
    span_hit  = 1'b0;
    span_idx  = '0;
    for (int i = NF - 1; i >= 0; i--) begin
      if (addr == lo_tab[i*AW +: AW]) begin
        entry_hit = 1'b1;
        entry_idx = FW'(i);
      end
      if (in_span(32'(addr), 32'(lo_tab[i*AW +: AW]), 32'(hi_tab[i*AW +: AW]))) begin
        span_hit = 1'b1;
        span_idx = FW'(i);
      end
    end
  end
endmodule

// File: rtl/cfm_cnt_bank.sv
module cfm_cnt_bank #(
  parameter int NF = 4,
  parameter int CW = 8,
  localparam int FW = $clog2(NF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic [FW-1:0]    inc_idx,
  input  logic             dec_en,
  input  logic [FW-1:0]    dec_idx,
  output logic [NF*CW-1:0] cnt_flat
);
  for (genvar f = 0; f < NF; f++) begin : g_cnt
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (inc_en && inc_idx == FW'(f) && cnt_q != {CW{1'b1}}) begin
        cnt_q <= cnt_q + 1'b1;
      end else if (dec_en && dec_idx == FW'(f) && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
    assign cnt_flat[f*CW +: CW] = cnt_q;
  end

  // R10
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_en && !dec_en) |=> $stable(cnt_flat));
endmodule

// File: rtl/cfm_monitor.sv
module cfm_monitor
  import cfm_pkg::*;
#(
  parameter int AW = 16,
  parameter int NF = 4,
  parameter int NE = 4,
  parameter int CW = 8,
  localparam int FW = $clog2(NF),
  localparam int RW = NE * AW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_vld,
  input  logic                bus_wr,
  input  logic [AW-1:0]       bus_addr,
  input  logic [OPW-1:0]      bus_opc,
  input  logic [AW-1:0]       code_lo,
  input  logic [AW-1:0]       code_hi,
  input  logic [NF*AW-1:0]    fn_lo_tab,
  input  logic [NF*AW-1:0]    fn_hi_tab,
  input  logic [NF*RW-1:0]    call_tab,
  input  logic [NF*NE-1:0]    call_vld,
  input  logic [NF*RW-1:0]    ret_tab,
  input  logic [NF*NE-1:0]    ret_vld,
  input  logic [RW-1:0]       sj_tab,
  input  logic [NE-1:0]       sj_vld,
  input  logic [FW-1:0]       lj_fn,
  output logic [2:0]          mode_o,
  output logic [FW-1:0]       act_fn,
  output logic [NF*CW-1:0]    call_cnt,
  output logic                code_atk,
  output logic                ctrl_atk,
  output logic [AW-1:0]       diag_src,
  output logic [AW-1:0]       diag_dst
);

  cfm_mode_e     mode_q, mode_d;
  logic [FW-1:0] act_q, act_d;
  logic [AW-1:0] last_fetch_q, src_q, dst_q;

  // Named internal events
  logic          in_code, fetch_evt, viol_code, viol_ctrl, viol_evt;
  logic          call_hit, ret_hit, sj_hit, act_span_hit;
  logic          entry_hit, span_hit;
  logic [FW-1:0] entry_idx, span_idx;
  logic          inc_en, dec_en;
  cfm_mode_e     dec_mode;

  assign in_code   = in_span(32'(bus_addr), 32'(code_lo), 32'(code_hi));
  assign fetch_evt = bus_vld && (mode_q == MD_DISP) && in_code && !bus_wr;

  cfm_op_decode u_dec (.opc(bus_opc), .next_mode(dec_mode));

  cfm_fn_locate #(.AW(AW), .NF(NF)) u_loc (
    .addr(bus_addr), .lo_tab(fn_lo_tab), .hi_tab(fn_hi_tab),
    .entry_hit(entry_hit), .entry_idx(entry_idx),
    .span_hit(span_hit), .span_idx(span_idx)
  );

  cfm_edge_match #(.AW(AW), .NE(NE)) u_call_em (
    .addr(bus_addr), .tab(call_tab[act_q*RW +: RW]),
    .vld(call_vld[act_q*NE +: NE]), .hit(call_hit)
  );

  cfm_edge_match #(.AW(AW), .NE(NE)) u_ret_em (
    .addr(bus_addr), .tab(ret_tab[act_q*RW +: RW]),
    .vld(ret_vld[act_q*NE +: NE]), .hit(ret_hit)
  );

  cfm_edge_match #(.AW(AW), .NE(NE)) u_sj_em (
    .addr(bus_addr), .tab(sj_tab), .vld(sj_vld), .hit(sj_hit)
  );

  assign act_span_hit = in_span(32'(bus_addr), 32'(fn_lo_tab[act_q*AW +: AW]),
                                32'(fn_hi_tab[act_q*AW +: AW]));

  always_comb begin
    mode_d    = mode_q;
    act_d     = act_q;
    inc_en    = 1'b0;
    dec_en    = 1'b0;
    viol_code = 1'b0;
    viol_ctrl = 1'b0;
    if (bus_vld) begin
      case (mode_q)
        MD_DISP: begin
          if (in_code) begin
            if (bus_wr) viol_code = 1'b1;
            else        mode_d    = dec_mode;
          end
        end
        MD_DCALL: begin
          mode_d = MD_DISP;
          if (entry_hit) begin
            act_d  = entry_idx;
            inc_en = 1'b1;
          end else begin
            viol_ctrl = 1'b1;
          end
        end
        MD_ICALL: begin
          mode_d = MD_DISP;
          if (call_hit && entry_hit) begin
            act_d  = entry_idx;
            inc_en = 1'b1;
          end else begin
            viol_ctrl = 1'b1;
          end
        end
        MD_RET: begin
          mode_d = MD_DISP;
          if (ret_hit && span_hit) begin
            act_d  = span_idx;
            dec_en = 1'b1;
          end else begin
            viol_ctrl = 1'b1;
          end
        end
        MD_IJMP: begin
          mode_d = MD_DISP;
          if (act_q == lj_fn) begin
            if (sj_hit && span_hit) act_d = span_idx;
            else                    viol_ctrl = 1'b1;
          end else if (!act_span_hit) begin
            viol_ctrl = 1'b1;
          end
        end
        MD_LDST: begin
          mode_d = MD_DISP;
          if (in_code && bus_wr) viol_code = 1'b1;
        end
        default: ;
      endcase
      if (viol_code) mode_d = MD_CODE_ATK;
      if (viol_ctrl) mode_d = MD_CTRL_ATK;
    end
  end

  assign viol_evt = viol_code || viol_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= MD_DISP;
      act_q        <= '0;
      last_fetch_q <= '0;
      src_q        <= '0;
      dst_q        <= '0;
    end else begin
      mode_q <= mode_d;
      act_q  <= act_d;
      if (fetch_evt) last_fetch_q <= bus_addr;
      if (viol_evt) begin
        src_q <= last_fetch_q;
        dst_q <= bus_addr;
      end
    end
  end

  cfm_cnt_bank #(.NF(NF), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .inc_en(inc_en), .inc_idx(act_q),
    .dec_en(dec_en), .dec_idx(span_idx),
    .cnt_flat(call_cnt)
  );

  assign mode_o   = mode_q;
  assign act_fn   = act_q;
  assign code_atk = (mode_q == MD_CODE_ATK);
  assign ctrl_atk = (mode_q == MD_CTRL_ATK);
  assign diag_src = src_q;
  assign diag_dst = dst_q;

  // R2
  idle_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_vld |=> ($stable(mode_q) && $stable(act_q)));

  // R3
  code_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld && bus_wr && in_code && mode_q == MD_DISP) |=> code_atk);

  // R4
  task_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld && is_task(mode_q)) |=> (mode_q == MD_DISP || is_attack(mode_q)));

  // R6
  icall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld && mode_q == MD_ICALL && !call_hit) |=> ctrl_atk);

  // R10
  code_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_atk |=> code_atk);

  // R10
  ctrl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_atk |=> ctrl_atk);

  // R10
  frozen_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_atk || ctrl_atk) |=> ($stable(act_q) && $stable(src_q) && $stable(dst_q)));

endmodule

// File: tb/cfm_monitor_bench.sv
module cfm_monitor_bench;
  localparam int AW = 16;
  localparam int NF = 4;
  localparam int NE = 4;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_vld = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [5:0]  bus_opc = '0;
  logic [2:0]  mode_o;
  logic [1:0]  act_fn;
  logic [31:0] call_cnt;
  logic code_atk, ctrl_atk;
  logic [15:0] diag_src, diag_dst;

  always #4 clk = ~clk;

  // Model: main 0100-01FF, foo 0200-02FF, bar 0300-03FF, nonlocal-jump fn 0400-04FF
  localparam logic [63:0]  FN_LO = {16'h0400, 16'h0300, 16'h0200, 16'h0100};
  localparam logic [63:0]  FN_HI = {16'h04FF, 16'h03FF, 16'h02FF, 16'h01FF};
  localparam logic [255:0] CALLS = {64'h0,
                                    16'h0, 16'h0, 16'h0, 16'h0200,
                                    16'h0, 16'h0, 16'h0, 16'h0300,
                                    16'h0300, 16'h0205, 16'h0400, 16'h0200};
  localparam logic [15:0]  CALLV = {4'b0000, 4'b0001, 4'b0001, 4'b0111};
  localparam logic [255:0] RETS  = {16'h0, 16'h0, 16'h0, 16'h0131,
                                    16'h0, 16'h0, 16'h0231, 16'h0221,
                                    16'h0, 16'h0, 16'h0311, 16'h0111,
                                    64'h0};
  localparam logic [15:0]  RETV  = {4'b0001, 4'b0001, 4'b0011, 4'b0000};
  localparam logic [63:0]  SJ    = {16'h0, 16'h0, 16'h0150, 16'h0140};

  cfm_monitor #(.AW(AW), .NF(NF), .NE(NE), .CW(CW)) u_cfm_monitor (
    .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_opc(bus_opc),
    .code_lo(16'h0100), .code_hi(16'h0FFF),
    .fn_lo_tab(FN_LO), .fn_hi_tab(FN_HI),
    .call_tab(CALLS), .call_vld(CALLV), .ret_tab(RETS), .ret_vld(RETV),
    .sj_tab(SJ), .sj_vld(4'b0011), .lj_fn(2'd3),
    .mode_o(mode_o), .act_fn(act_fn), .call_cnt(call_cnt),
    .code_atk(code_atk), .ctrl_atk(ctrl_atk),
    .diag_src(diag_src), .diag_dst(diag_dst)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // One bus cycle; outputs sampled 2 ns after the capturing edge.
  task automatic step(input logic v, input logic w, input logic [15:0] a, input logic [5:0] o);
    bus_vld = v; bus_wr = w; bus_addr = a; bus_opc = o;
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_vld = 1'b0; bus_wr = 1'b0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
  endtask

  typedef struct packed {
    logic        v;
    logic        w;
    logic [15:0] a;
    logic [5:0]  o;
    logic [2:0]  m;
    logic [1:0]  f;
    logic [31:0] c;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 16'h0100, 6'h00, 3'd0, 2'd0, 32'h00000000},  // R4 plain fetch
    '{1'b1, 1'b0, 16'h8000, 6'h03, 3'd0, 2'd0, 32'h00000000},  // R3 data region
    '{1'b1, 1'b0, 16'h0110, 6'h01, 3'd1, 2'd0, 32'h00000000},  // R4 direct call
    '{1'b1, 1'b0, 16'h0200, 6'h00, 3'd0, 2'd1, 32'h00000001},  // R5
    '{1'b1, 1'b0, 16'h0210, 6'h02, 3'd2, 2'd1, 32'h00000001},
    '{1'b1, 1'b0, 16'h0300, 6'h00, 3'd0, 2'd2, 32'h00000101},  // R6
    '{1'b1, 1'b0, 16'h0305, 6'h08, 3'd0, 2'd2, 32'h00000101},  // R4 branch ignored
    '{1'b1, 1'b0, 16'h0310, 6'h02, 3'd2, 2'd2, 32'h00000101},
    '{1'b1, 1'b0, 16'h0200, 6'h00, 3'd0, 2'd1, 32'h00010101},  // R6 recursion
    '{1'b1, 1'b0, 16'h0220, 6'h05, 3'd5, 2'd1, 32'h00010101},
    '{1'b1, 1'b0, 16'h0150, 6'h03, 3'd0, 2'd1, 32'h00010101},  // R9
    '{1'b1, 1'b0, 16'h0230, 6'h03, 3'd3, 2'd1, 32'h00010101},
    '{1'b1, 1'b0, 16'h0311, 6'h00, 3'd0, 2'd2, 32'h00000101},  // R7
    '{1'b1, 1'b0, 16'h0320, 6'h04, 3'd4, 2'd2, 32'h00000101},
    '{1'b1, 1'b0, 16'h0380, 6'h00, 3'd0, 2'd2, 32'h00000101},  // R8 local
    '{1'b1, 1'b0, 16'h0330, 6'h03, 3'd3, 2'd2, 32'h00000101},
    '{1'b1, 1'b0, 16'h0221, 6'h00, 3'd0, 2'd1, 32'h00000001},  // R7
    '{1'b1, 1'b0, 16'h0240, 6'h03, 3'd3, 2'd1, 32'h00000001},
    '{1'b1, 1'b0, 16'h0111, 6'h00, 3'd0, 2'd0, 32'h00000000},  // R7
    '{1'b1, 1'b0, 16'h0120, 6'h01, 3'd1, 2'd0, 32'h00000000},
    '{1'b1, 1'b0, 16'h0400, 6'h00, 3'd0, 2'd3, 32'h00000001},  // R5
    '{1'b1, 1'b0, 16'h0410, 6'h04, 3'd4, 2'd3, 32'h00000001},
    '{1'b1, 1'b0, 16'h0150, 6'h00, 3'd0, 2'd0, 32'h00000001},  // R8 nonlocal
    '{1'b0, 1'b1, 16'h0100, 6'h01, 3'd0, 2'd0, 32'h00000001},  // R2
    '{1'b1, 1'b0, 16'h0130, 6'h06, 3'd5, 2'd0, 32'h00000001},
    '{1'b1, 1'b1, 16'h8004, 6'h00, 3'd0, 2'd0, 32'h00000001},  // R3 data write
    '{1'b1, 1'b0, 16'h0160, 6'h03, 3'd3, 2'd0, 32'h00000001},
    '{1'b1, 1'b0, 16'h0111, 6'h00, 3'd7, 2'd0, 32'h00000001},  // R7 no site
    '{1'b1, 1'b0, 16'h0110, 6'h01, 3'd7, 2'd0, 32'h00000001}   // R10 frozen
  };

  // Violation scenario: prefix steps then a final destination expected to trip.
  task automatic expect_ctrl(input string req);
    check({req, " ctrl flag"}, 32'(ctrl_atk), 32'd1);
    check({req, " mode"}, 32'(mode_o), 32'd7);
  endtask

  logic done = 1'b0;

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got hang expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 mode", 32'(mode_o), 32'd0);
    check("R1 act", 32'(act_fn), 32'd0);
    check("R1 cnt", call_cnt, 32'd0);
    check("R1 flags", {30'd0, code_atk, ctrl_atk}, 32'd0);
    check("R1 diag", {diag_src, diag_dst}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].v, VECS[i].w, VECS[i].a, VECS[i].o);
      check($sformatf("R4 row%0d mode", i), 32'(mode_o), 32'(VECS[i].m));
      check($sformatf("R5 row%0d act", i), 32'(act_fn), 32'(VECS[i].f));
      check($sformatf("R7 row%0d cnt", i), call_cnt, VECS[i].c);
    end
    // R11 diagnosis after the forged return
    check("R11 src", 32'(diag_src), 32'h0160);
    check("R11 dst", 32'(diag_dst), 32'h0111);
    check("R10 code flag low", 32'(code_atk), 32'd0);

    // R3 code write in dispatcher, R11, R10
    do_reset();
    step(1, 0, 16'h0100, 6'h00);
    step(1, 1, 16'h0105, 6'h00);
    check("R3 code flag", 32'(code_atk), 32'd1);
    check("R3 mode", 32'(mode_o), 32'd6);
    check("R11 src", 32'(diag_src), 32'h0100);
    check("R11 dst", 32'(diag_dst), 32'h0105);
    step(1, 0, 16'h0110, 6'h01);
    step(1, 0, 16'h0200, 6'h00);
    check("R10 hold mode", 32'(mode_o), 32'd6);
    check("R10 hold act", 32'(act_fn), 32'd0);
    check("R10 hold cnt", call_cnt, 32'd0);

    // R6 listed edge that is not an entry
    do_reset();
    step(1, 0, 16'h0110, 6'h02);
    step(1, 0, 16'h0205, 6'h00);
    expect_ctrl("R6 non-entry");

    // R6 entry present only in an invalid slot
    do_reset();
    step(1, 0, 16'h0110, 6'h02);
    step(1, 0, 16'h0300, 6'h00);
    expect_ctrl("R6 invalid slot");
    check("R6 act kept", 32'(act_fn), 32'd0);

    // R5 direct call into middle of a function
    do_reset();
    step(1, 0, 16'h0110, 6'h01);
    step(1, 0, 16'h0250, 6'h00);
    expect_ctrl("R5 non-entry");
    check("R5 cnt kept", call_cnt, 32'd0);

    // R8 indirect jump leaving the active function
    do_reset();
    step(1, 0, 16'h0110, 6'h04);
    step(1, 0, 16'h0200, 6'h00);
    expect_ctrl("R8 outside span");

    // R8 nonlocal jump fn landing inside itself but not on a site
    do_reset();
    step(1, 0, 16'h0120, 6'h01);
    step(1, 0, 16'h0400, 6'h00);
    step(1, 0, 16'h0410, 6'h04);
    step(1, 0, 16'h0420, 6'h00);
    expect_ctrl("R8 not a site");

    // R7 return to a site whose valid bit is clear
    do_reset();
    step(1, 0, 16'h0110, 6'h01);
    step(1, 0, 16'h0200, 6'h00);
    step(1, 0, 16'h0210, 6'h02);
    step(1, 0, 16'h0300, 6'h00);
    step(1, 0, 16'h0330, 6'h03);
    step(1, 0, 16'h0231, 6'h00);
    expect_ctrl("R7 invalid site");
    check("R7 act kept", 32'(act_fn), 32'd2);

    // R9 / R3 store writing into code
    do_reset();
    step(1, 0, 16'h0130, 6'h06);
    step(1, 1, 16'h0180, 6'h00);
    check("R9 store into code", 32'(code_atk), 32'd1);
    check("R11 dst store", 32'(diag_dst), 32'h0180);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule